// File: doc/BRIEF.md
# Predicated Vector Halfword Store Sequencer

This block turns one vector store operation into a series of 16-bit memory writes. On a start pulse it captures a vector register value, a predicate with one bit per vector byte, a 64-bit base (taken from either a general register input or the stack pointer input) and a 64-bit scalar index. It then steps through the vector from element 0 upward. For each element whose governing predicate bit is set, it issues one write of the element's low halfword. The write address is the base plus twice a running index.

The element width is chosen for each operation by a 2-bit size code. The running index advances once per element, whether or not that element is written. The index value supplied by the caller is only read and is never returned. Two encodings are rejected outright: they raise an illegal flag and produce no memory traffic. A memory write port with valid/ready back-pressure lets a slow memory stall the walk. A start/busy/done handshake frames each operation.

Top module: `vhs_top`

## Requirements
- R1: A size code of 0 is rejected. Done pulses with illegal high, and no write handshake takes place during that operation.
- R2: An index selector of 31 is rejected in the same way: illegal is high with done, and no write is made.
- R3: Size codes 1, 2 and 3 select 16, 32 and 64-bit elements. The operation visits VLEN/width elements in ascending order, starting with element 0.
- R4: The write address for element e is base + 2*(index + e), computed modulo 2^64. The running index wraps at 2^64 as well.
- R5: An element whose governing bit is 0 produces no write, but it still advances the running index.
- R6: The write data for an element is its low 16 bits. Element e occupies vector bits [e*width +: width].
- R7: The governing bit for element e is predicate bit e*(width/8). All other predicate bits have no effect.
- R8: A base selector of 31 takes the base from the stack pointer input. Any other value takes it from the general register input.
- R9: While write valid is high and ready is low, valid stays high and the address and data hold their values on the next cycle.
- R10: Busy rises on the cycle after an accepted start. Done pulses for exactly one cycle after the last element has been visited, including when no element is active. Busy falls on the following cycle. No write is offered outside an operation.
- R11: A start pulse while busy is ignored, so the operation in flight is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| sizeCode | input | 2 | Element width code |
| idxSel | input | 5 | Index register selector (31 is illegal) |
| baseSel | input | 5 | Base register selector (31 picks stack pointer) |
| vecData | input | VLEN | Vector register value |
| predMask | input | VLEN/8 | Predicate, one bit per vector byte |
| gprBase | input | 64 | General register base value |
| spBase | input | 64 | Stack pointer base value |
| idxIn | input | 64 | Starting index value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | High with done when the encoding was rejected |
| wrValid | output | 1 | Write request valid |
| wrReady | input | 1 | Memory accepts the write |
| wrAddr | output | 64 | Byte address of the 2-byte write |
| wrData | output | 16 | Halfword to write |

## Verification
A wrong internal state shows up at the write port itself, within the same operation. A mis-shifted predicate or vector register appears as a missing, extra or wrong halfword. An index that stalls on inactive elements offsets every later address by a multiple of two. An element counter that is off by one moves done by one cycle, or emits a write beyond the last element. The sweeps cover every predicate pattern for every width with back-pressure applied, so each such fault differs from the computed write list of some operation before that operation's done pulse.

// File: rtl/vhs_pkg.sv
package vhs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } vhsState_t;

  typedef struct packed {
    logic load;
    logic advance;
  } vhsStrobe_t;

  localparam logic [4:0] SEL_RESERVED = 5'd31;

  // element width in bits for a legal size code (1..3)
  function automatic int unsigned elemBits(input logic [1:0] code);
    return 32'd8 << code;
  endfunction

endpackage

// File: rtl/vhs_ctrl.sv
module vhs_ctrl
  import vhs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       badEncoding,
  input  logic       curActive,
  input  logic       lastElem,
  input  logic       wrReady,
  output vhsStrobe_t strobe,
  output logic       busy,
  output logic       done,
  output logic       illegal,
  output logic       wrValid
);

  vhsState_t state, nextState;
  logic      illReg;

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.load = 1'b1;
          nextState   = badEncoding ? ST_FIN : ST_RUN;
        end
      end
      ST_RUN: begin
        // inactive elements retire in one cycle; active ones wait for ready
        if (!curActive || wrReady) begin
          strobe.advance = 1'b1;
          if (lastElem) nextState = ST_FIN;
        end
      end
      ST_FIN:  nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      illReg <= 1'b0;
    end else begin
      state <= nextState;
      if (strobe.load) illReg <= badEncoding;
    end
  end

  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_FIN);
  assign illegal = (state == ST_FIN) && illReg;
  assign wrValid = (state == ST_RUN) && curActive;

endmodule

// File: rtl/vhs_dpath.sv
module vhs_dpath
  import vhs_pkg::*;
#(
  parameter int VLEN = 256,
  parameter int PLEN = VLEN / 8,
  parameter int CNTW = $clog2(VLEN / 16 + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  vhsStrobe_t      strobe,
  input  logic [1:0]      sizeCode,
  input  logic [4:0]      baseSel,
  input  logic [VLEN-1:0] vecData,
  input  logic [PLEN-1:0] predMask,
  input  logic [63:0]     gprBase,
  input  logic [63:0]     spBase,
  input  logic [63:0]     idxIn,
  output logic            curActive,
  output logic            lastElem,
  output logic [63:0]     wrAddr,
  output logic [15:0]     wrData
);

  localparam int MAXELEMS = VLEN / 16;

  logic [VLEN-1:0] vecReg, vecNext;
  logic [PLEN-1:0] predReg, predNext;
  logic [63:0]     baseReg;
  logic [63:0]     idxReg;
  logic [1:0]      sizeReg;
  logic [CNTW-1:0] elemCnt, elemLoad;

  // one shifter per legal width; the stored size code picks the result
  logic [VLEN-1:0] vecSh  [1:3];
  logic [PLEN-1:0] predSh [1:3];

  for (genvar s = 1; s <= 3; s++) begin : g_width
    localparam int WB = 8 << s;
    assign vecSh[s]  = vecReg >> WB;
    assign predSh[s] = predReg >> (WB / 8);
  end

  always_comb begin
    unique case (sizeReg)
      2'd2:    begin vecNext = vecSh[2]; predNext = predSh[2]; end
      2'd3:    begin vecNext = vecSh[3]; predNext = predSh[3]; end
      default: begin vecNext = vecSh[1]; predNext = predSh[1]; end
    endcase
  end

  always_comb begin
    unique case (sizeCode)
      2'd2:    elemLoad = CNTW'(MAXELEMS / 2);
      2'd3:    elemLoad = CNTW'(MAXELEMS / 4);
      default: elemLoad = CNTW'(MAXELEMS);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecReg  <= '0;
      predReg <= '0;
      baseReg <= '0;
      idxReg  <= '0;
      sizeReg <= 2'd1;
      elemCnt <= '0;
    end else if (strobe.load) begin
      vecReg  <= vecData;
      predReg <= predMask;
      baseReg <= (baseSel == SEL_RESERVED) ? spBase : gprBase;
      idxReg  <= idxIn;
      sizeReg <= sizeCode;
      elemCnt <= elemLoad;
    end else if (strobe.advance) begin
      vecReg  <= vecNext;
      predReg <= predNext;
      idxReg  <= idxReg + 64'd1;
      elemCnt <= elemCnt - CNTW'(1);
    end
  end

  assign curActive = predReg[0];
  assign lastElem  = (elemCnt == CNTW'(1));
  assign wrAddr    = baseReg + (idxReg << 1);
  assign wrData    = vecReg[15:0];

endmodule

// File: rtl/vhs_top.sv
module vhs_top
  import vhs_pkg::*;
#(
  parameter int VLEN = 256,
  parameter int PLEN = VLEN / 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [1:0]      sizeCode,
  input  logic [4:0]      idxSel,
  input  logic [4:0]      baseSel,
  input  logic [VLEN-1:0] vecData,
  input  logic [PLEN-1:0] predMask,
  input  logic [63:0]     gprBase,
  input  logic [63:0]     spBase,
  input  logic [63:0]     idxIn,
  output logic            busy,
  output logic            done,
  output logic            illegal,
  output logic            wrValid,
  input  logic            wrReady,
  output logic [63:0]     wrAddr,
  output logic [15:0]     wrData
);

  localparam int CNTW = $clog2(VLEN / 16 + 1);

  vhsStrobe_t strobe;
  logic       curActive;
  logic       lastElem;
  logic       badEncoding;

  assign badEncoding = (sizeCode == 2'd0) || (idxSel == SEL_RESERVED);

  vhs_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .badEncoding(badEncoding),
    .curActive  (curActive),
    .lastElem   (lastElem),
    .wrReady    (wrReady),
    .strobe     (strobe),
    .busy       (busy),
    .done       (done),
    .illegal    (illegal),
    .wrValid    (wrValid)
  );

  vhs_dpath #(.VLEN(VLEN), .PLEN(PLEN), .CNTW(CNTW)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .sizeCode (sizeCode),
    .baseSel  (baseSel),
    .vecData  (vecData),
    .predMask (predMask),
    .gprBase  (gprBase),
    .spBase   (spBase),
    .idxIn    (idxIn),
    .curActive(curActive),
    .lastElem (lastElem),
    .wrAddr   (wrAddr),
    .wrData   (wrData)
  );

endmodule

// File: rtl/vhs_checker.sv
module vhs_checker (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        illegal,
  input logic        wrValid,
  input logic        wrReady,
  input logic [63:0] wrAddr,
  input logic [15:0] wrData
);

  logic wroteThisOp;

  always_ff @(posedge clk) begin
    if (!rstN)                    wroteThisOp <= 1'b0;
    else if (start && !busy)      wroteThisOp <= 1'b0;
    else if (wrValid && wrReady)  wroteThisOp <= 1'b1;
  end

  assert_hold_stalled_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> (wrValid && $stable(wrAddr) && $stable(wrData)));

  // R1 and R2: a rejected operation completes without any write
  assert_reject_no_write_R1: assert property (@(posedge clk) disable iff (!rstN)
    (done && illegal) |-> !wroteThisOp);

  assert_illegal_with_done_R2: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> done);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  assert_write_in_op_R10: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> (busy && !done));

  assert_start_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

endmodule

bind vhs_top vhs_checker u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .illegal(illegal),
  .wrValid(wrValid),
  .wrReady(wrReady),
  .wrAddr (wrAddr),
  .wrData (wrData)
);

// File: tb/vhs_top_tb.sv
module vhs_top_tb;

  localparam int VLEN = 64;
  localparam int PLEN = VLEN / 8;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            start = 1'b0;
  logic [1:0]      sizeCode = 2'd1;
  logic [4:0]      idxSel = 5'd0;
  logic [4:0]      baseSel = 5'd0;
  logic [VLEN-1:0] vecData = '0;
  logic [PLEN-1:0] predMask = '0;
  logic [63:0]     gprBase = '0;
  logic [63:0]     spBase = '0;
  logic [63:0]     idxIn = '0;
  logic            busy, done, illegal, wrValid;
  logic            wrReady = 1'b0;
  logic [63:0]     wrAddr;
  logic [15:0]     wrData;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #2 clk = ~clk;  // 250 MHz

  vhs_top #(.VLEN(VLEN)) u_dut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      check(1'b0, "R10", "watchdog expired", 64'(cycles), 64'd150000);
      summary();
    end
  end

  // one operation: drive, collect writes, compare with computed list
  task automatic runOp(input int op, input logic [1:0] sz, input logic [4:0] iSel,
                       input logic [4:0] bSel, input logic [VLEN-1:0] vec,
                       input logic [PLEN-1:0] pred, input logic [63:0] gpr,
                       input logic [63:0] sp, input logic [63:0] idx,
                       input bit extraStart);
    logic [63:0] expAddr [8];
    logic [15:0] expData [8];
    logic [63:0] gotAddr [8];
    logic [15:0] gotData [8];
    int nExp = 0;
    int nGot = 0;
    bit bad  = (sz == 2'd0) || (iSel == 5'd31);
    bit prevStall = 1'b0;
    logic [63:0] prevAddr = '0;
    logic [15:0] prevData = '0;
    bit seenDone = 1'b0;
    logic [63:0] base = (bSel == 5'd31) ? sp : gpr;

    if (!bad) begin
      int eb = 8 << sz;
      for (int e = 0; e < VLEN / eb; e++) begin
        if (pred[e * (eb / 8)]) begin
          expAddr[nExp] = base + 64'd2 * (idx + 64'(e));
          expData[nExp] = vec[e * eb +: 16];
          nExp++;
        end
      end
    end

    @(negedge clk);
    sizeCode = sz; idxSel = iSel; baseSel = bSel; vecData = vec;
    predMask = pred; gprBase = gpr; spBase = sp; idxIn = idx; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R10", "busy after start", 64'(busy), 64'd1);

    for (int cyc = 0; cyc < 200; cyc++) begin
      if (extraStart && cyc == 1) begin
        start = 1'b1; vecData = ~vec; predMask = ~pred; idxIn = idx + 64'd100;
      end else if (extraStart && cyc == 2) begin
        start = 1'b0; vecData = vec; predMask = pred; idxIn = idx;
      end
      wrReady = ((cyc + op) % 3) != 2;
      #1;
      if (prevStall) begin
        check(wrValid && wrAddr == prevAddr && wrData == prevData, "R9",
              "stalled write changed", wrAddr, prevAddr);
      end
      prevStall = wrValid && !wrReady;
      prevAddr  = wrAddr;
      prevData  = wrData;
      if (wrValid && wrReady) begin
        if (nGot < 8) begin
          gotAddr[nGot] = wrAddr;
          gotData[nGot] = wrData;
        end
        nGot++;
      end
      if (done) begin
        seenDone = 1'b1;
        break;
      end
      @(negedge clk);
    end

    check(seenDone, "R10", "done never pulsed", 64'(seenDone), 64'd1);
    check(illegal == bad, bad ? (sz == 2'd0 ? "R1" : "R2") : "R3",
          "illegal flag at done", 64'(illegal), 64'(bad));
    check(nGot == nExp, (pred == '0) ? "R5" : "R3", "write count",
          64'(nGot), 64'(nExp));
    for (int k = 0; k < nExp && k < nGot; k++) begin
      check(gotAddr[k] == expAddr[k], (bSel == 5'd31) ? "R8" : "R4", "address",
            gotAddr[k], expAddr[k]);
      check(gotData[k] == expData[k], (sz == 2'd1) ? "R6" : "R7", "data",
            64'(gotData[k]), 64'(expData[k]));
    end
    @(negedge clk);
    wrReady = 1'b0;
    check(!done && !busy, extraStart ? "R11" : "R10", "done/busy after pulse",
          {62'd0, done, busy}, 64'd0);
  endtask

  function automatic logic [VLEN-1:0] mixVec(input int op);
    logic [VLEN-1:0] v;
    for (int k = 0; k < VLEN / 16; k++)
      v[k * 16 +: 16] = 16'(op * 40503 + k * 9029 + 16'h5a3c);
    return v;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(!busy && !done && !illegal && !wrValid, "R10", "reset state",
          {60'd0, busy, done, illegal, wrValid}, 64'd0);

    // R3 R5 R6 R7: every predicate pattern for every legal width
    for (int sz = 1; sz <= 3; sz++) begin
      for (int p = 0; p < (1 << PLEN); p++) begin
        int op = sz * 256 + p;
        logic [63:0] gpr = (p % 5 == 0) ? 64'hFFFF_FFFF_FFFF_FFF8 : 64'(op) * 64'h1000;
        logic [63:0] idx = (p % 7 == 0) ? 64'hFFFF_FFFF_FFFF_FFFE : 64'(p * 3);
        runOp(op, 2'(sz), 5'(op % 31), 5'(op % 32), mixVec(op), PLEN'(p),
              gpr, 64'hC000_0000_0000_0100 + 64'(op), idx, 1'b0);
      end
    end

    // R8: stack pointer base selected
    runOp(5, 2'd1, 5'd3, 5'd31, mixVec(5), '1, 64'h1111, 64'h8000_0000, 64'd10, 1'b0);
    // R1: size code 0 rejected even with all lanes active
    runOp(6, 2'd0, 5'd3, 5'd2, mixVec(6), '1, 64'h2000, 64'h0, 64'd0, 1'b0);
    // R2: index selector 31 rejected
    runOp(7, 2'd2, 5'd31, 5'd2, mixVec(7), '1, 64'h2000, 64'h0, 64'd0, 1'b0);
    // R11: second start during a run is ignored
    runOp(8, 2'd1, 5'd4, 5'd1, mixVec(8), 8'h55, 64'h4000, 64'h0, 64'd2, 1'b1);
    // R4: address wraps modulo 2^64
    runOp(9, 2'd1, 5'd4, 5'd1, mixVec(9), '1, 64'hFFFF_FFFF_FFFF_FFFC, 64'h0, 64'd0, 1'b0);

    summary();
  end

endmodule